// File: doc/BRIEF.md
# ADC Control Register Sequencer

This block is the digital front end of an 8-bit successive-approximation converter. Software talks to it through a byte-wide control register and a read-only result register. From the control byte the block derives the conversion step clock, the 4-bit select code for the analog multiplexer, and the start and abort events sent to the converter. It also runs the successive-approximation loop itself, using a single comparator bit returned by the analog side.

Setting the start bit launches a conversion. That bit then reads back as 1 while the conversion is busy, and the hardware clears it when the last step finishes. Software has no way to clear it by writing 0. The only way to stop a running conversion is to clear the module enable, which abandons the conversion and leaves the result untouched. The step clock is either the system clock divided by 2, 8 or 32, or the ticks of an external slow clock that arrive as an enable input.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset, the control byte reads 0x00 and the result reads 0x00. The outputs conv_start, conv_abort, done_pulse and conv_tick are all 0.
- R2: The control byte uses this layout: bits 7:6 clock source, bits 5:3 channel code, bit 2 busy/start, bit 1 internal-source flag, bit 0 enable. A write that does not start a conversion reads back exactly as written, with bit 2 equal to 0. rd_addr=0 reads the control byte and rd_addr=1 reads the result.
- R3: chan_sel equals {bit 1, bits 5:3} of the control byte. This includes the reserved internal codes 010 to 111, which are driven as written, and a conversion on such a code runs normally.
- R4: A write with bit 2 = 1 and bit 0 = 1, made while the enable bit is already 1 and no conversion is running, sets the busy bit. In the following cycle conv_start is high for one cycle and sar_code is 0x80.
- R5: A write with bit 2 = 1 while the stored enable bit is 0 is ignored. The busy bit stays 0 and conv_start stays 0, even when the same write sets the enable bit.
- R6: While busy, a write with bit 2 = 0 and bit 0 = 1 does not clear the busy bit, and the conversion completes normally.
- R7: The clock source codes 00, 01 and 10 set the step period to 2, 8 and 32 system clocks. Counting from the start edge, the busy bit clears exactly 8 periods later.
- R8: With clock source code 11, a step happens only on cycles where slow_tick is high during a conversion. The 8th such tick completes the conversion.
- R9: Bits are resolved MSB first, one bit per step. A trial bit is kept when cmp_in is 1 and cleared when cmp_in is 0. sar_code presents the current trial code, so a comparator that reports vin >= sar_code yields result = vin.
- R10: On the edge that completes a conversion, the result register is loaded and the busy bit clears. done_pulse is high for exactly the next cycle. The result changes on no other edge.
- R11: A write with bit 0 = 0 during a conversion clears the busy bit on that edge and raises conv_abort for one cycle. It leaves the result unchanged, and no done_pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_addr | input | 1 | Read select: 0 control, 1 result |
| rd_data | output | 8 | Read data |
| slow_tick | input | 1 | One-cycle enable from the separate slow clock |
| cmp_in | input | 1 | Comparator bit: 1 when the input is at or above sar_code |
| chan_sel | output | 4 | Multiplexer select {internal flag, channel code} |
| sar_code | output | 8 | Current trial code for the converter DAC |
| conv_start | output | 1 | One-cycle pulse after a conversion starts |
| conv_abort | output | 1 | One-cycle pulse after a conversion is abandoned |
| conv_tick | output | 1 | High on cycles whose edge performs a SAR step |
| done_pulse | output | 1 | One-cycle pulse after the result is loaded |

## Verification
A corrupted busy bit or step counter shows up on the ports. The busy bit read back at the wrong cycle, or a done_pulse that comes early or late, exposes it, and the bench measures the edge count to completion exactly for every clock source. A corrupted trial register shows up on sar_code in the first cycle after the start, and in the final result one period per bit later. A lost abort is visible one cycle after the write, because conv_abort, the busy bit or the preserved result are then wrong.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CK_DIV_A = 2'd0,
        CK_DIV_B = 2'd1,
        CK_DIV_C = 2'd2,
        CK_SLOW  = 2'd3
    } clk_src_e;

    // Bit order of this struct is the software-visible byte layout.
    typedef struct packed {
        clk_src_e   src;
        logic [2:0] chs;
        logic       go;
        logic       intsel;
        logic       en;
    } ctrl_reg_t;

    localparam int unsigned CTRL_W = $bits(ctrl_reg_t);
    localparam int unsigned NUM_DIV = 3;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              done_evt,
    output ctrl_reg_t         ctrl_q,
    output logic              start_evt,
    output logic              abort_evt
);
    ctrl_reg_t wd;
    ctrl_reg_t ctrl_n;

    assign wd = ctrl_reg_t'(wr_data);

    // Start needs enable already set and stays set, and no conversion running.
    assign start_evt = wr_en && ctrl_q.en && wd.en && wd.go && !ctrl_q.go;
    assign abort_evt = wr_en && ctrl_q.go && !wd.en;

    always_comb begin
        ctrl_n = ctrl_q;
        if (done_evt) begin
            ctrl_n.go = 1'b0;
        end
        if (wr_en) begin
            ctrl_n.src    = wd.src;
            ctrl_n.chs    = wd.chs;
            ctrl_n.intsel = wd.intsel;
            ctrl_n.en     = wd.en;
            if (!wd.en) begin
                ctrl_n.go = 1'b0;
            end
        end
        if (start_evt) begin
            ctrl_n.go = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
        end
    end
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_seq_pkg::*;
#(
    parameter int unsigned DIV_A = 2,
    parameter int unsigned DIV_B = 8,
    parameter int unsigned DIV_C = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     slow_en,
    output logic     tick
);
    localparam int unsigned DIV_MAX = max3(DIV_A, DIV_B, DIV_C);
    localparam int unsigned CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam int unsigned DIV_TAB [NUM_DIV] = '{DIV_A, DIV_B, DIV_C};

    logic [CNT_W-1:0] cnt;
    logic [3:0]       hit;

    genvar g;
    generate
        for (g = 0; g < NUM_DIV; g++) begin : g_div
            assign hit[g] = (cnt == CNT_W'(DIV_TAB[g] - 1));
        end
    endgenerate
    assign hit[3] = slow_en;

    assign tick = run && hit[src];

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic             cmp,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result,
    output logic             done_evt,
    output logic             done_pulse
);
    localparam int unsigned IDX_W = (RES_W > 2) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] code_n;
    logic             step;

    assign step     = tick && !abort;
    assign done_evt = step && (idx == '0);

    always_comb begin
        code_n      = trial;
        code_n[idx] = cmp;
        if (idx != '0) begin
            code_n[idx - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial      <= '0;
            idx        <= '0;
            result     <= '0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= done_evt;
            if (start) begin
                trial <= MSB_ONLY;
                idx   <= IDX_W'(RES_W - 1);
            end else if (step) begin
                trial <= code_n;
                if (idx != '0) begin
                    idx <= idx - 1'b1;
                end else begin
                    result <= code_n;
                end
            end
        end
    end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W = 8,
    parameter int unsigned DIV_A = 2,
    parameter int unsigned DIV_B = 8,
    parameter int unsigned DIV_C = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_addr,
    output logic [7:0]       rd_data,
    input  logic             slow_tick,
    input  logic             cmp_in,
    output logic [3:0]       chan_sel,
    output logic [RES_W-1:0] sar_code,
    output logic             conv_start,
    output logic             conv_abort,
    output logic             conv_tick,
    output logic             done_pulse
);
    ctrl_reg_t        ctrl_q;
    logic             start_evt;
    logic             abort_evt;
    logic             done_evt;
    logic             tick;
    logic [RES_W-1:0] result_w;
    logic             go_w;
    logic             en_w;

    adc_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done_evt  (done_evt),
        .ctrl_q    (ctrl_q),
        .start_evt (start_evt),
        .abort_evt (abort_evt)
    );

    adc_tick_gen #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.go),
        .src     (ctrl_q.src),
        .slow_en (slow_tick),
        .tick    (tick)
    );

    adc_sar_engine #(
        .RES_W (RES_W)
    ) u_sar (
        .clk        (clk),
        .rst        (rst),
        .start      (start_evt),
        .abort      (abort_evt),
        .tick       (tick),
        .cmp        (cmp_in),
        .trial      (sar_code),
        .result     (result_w),
        .done_evt   (done_evt),
        .done_pulse (done_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            conv_start <= start_evt;
            conv_abort <= abort_evt;
        end
    end

    assign go_w      = ctrl_q.go;
    assign en_w      = ctrl_q.en;
    assign conv_tick = tick;
    assign chan_sel  = {ctrl_q.intsel, ctrl_q.chs};
    assign rd_data   = rd_addr ? 8'(result_w) : 8'(ctrl_q);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned RES_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             en,
    input logic             conv_start,
    input logic             conv_abort,
    input logic             conv_tick,
    input logic             done_pulse,
    input logic [RES_W-1:0] result
);
    p_go_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        go |-> en);

    p_start_from_enabled_idle_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (go && $past(en) && !$past(go)));

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (!go && $past(go)));

    p_result_moves_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done_pulse);

    p_abort_clean_r11: assert property (@(posedge clk) disable iff (rst)
        conv_abort |-> (!en && !go && !done_pulse && $past(go)));

    p_pulses_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({conv_start, conv_abort, done_pulse}));

    p_tick_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        conv_tick |-> go);
endmodule

bind adc_ctrl_seq adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .go         (go_w),
    .en         (en_w),
    .conv_start (conv_start),
    .conv_abort (conv_abort),
    .conv_tick  (conv_tick),
    .done_pulse (done_pulse),
    .result     (result_w)
);

// File: tb/sim_adc_ctrl_seq.sv
`timescale 1ns/1ps
module sim_adc_ctrl_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       slow_tick = 1'b0;
    logic       cmp_in;
    logic [3:0] chan_sel;
    logic [7:0] sar_code;
    logic       conv_start, conv_abort, conv_tick, done_pulse;
    logic [7:0] vin = 8'h00;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    // Comparator model: input at or above the trial code.
    assign cmp_in = (vin >= sar_code);

    adc_ctrl_seq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .slow_tick(slow_tick),
        .cmp_in(cmp_in), .chan_sel(chan_sel), .sar_code(sar_code),
        .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_tick(conv_tick), .done_pulse(done_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    // Counts edges after the start write until done_pulse shows.
    task automatic wait_done(output int k);
        k = 0;
        while (!done_pulse && k < 2000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); check("R1 ctrl", v, 8'h00);
        rd(1'b1, v); check("R1 result", v, 8'h00);
        check("R1 pulses", {conv_start, conv_abort, done_pulse, conv_tick}, 0);
    endtask

    task automatic t_layout;
        logic [7:0] v;
        wr(8'hA9);
        rd(1'b0, v); check("R2 readback A9", v, 8'hA9);
        check("R3 chan ext", chan_sel, 4'h5);
        wr(8'h5B);
        rd(1'b0, v); check("R2 readback 5B", v, 8'h5B);
        check("R3 chan reserved", chan_sel, 4'hB);
    endtask

    task automatic t_start_while_disabled;
        logic [7:0] v;
        wr(8'h00);
        wr(8'h05);
        rd(1'b0, v); check("R5 go stays 0", v, 8'h01);
        check("R5 no start", conv_start, 0);
        repeat (3) @(negedge clk);
        rd(1'b0, v); check("R5 still idle", v, 8'h01);
    endtask

    task automatic t_convert(input logic [1:0] src, input logic [7:0] val, input int div,
                             input logic [3:0] chan);
        logic [7:0] v;
        int k;
        vin = val;
        wr({src, chan[2:0], 1'b0, chan[3], 1'b1});
        wr({src, chan[2:0], 1'b1, chan[3], 1'b1});
        check("R4 start pulse", conv_start, 1);
        check("R9 first trial", sar_code, 8'h80);
        rd(1'b0, v); check("R4 busy set", v[2], 1);
        check("R3 chan during conv", chan_sel, chan);
        wait_done(k);
        check("R7 step timing", k, 8 * div);
        rd(1'b1, v); check("R9 result", v, val);
        rd(1'b0, v); check("R10 busy cleared", v[2], 0);
        @(negedge clk);
        check("R10 done one cycle", done_pulse, 0);
    endtask

    task automatic t_sw_clear_ignored;
        logic [7:0] v;
        int k;
        vin = 8'h3C;
        wr(8'h41);
        wr(8'h45);
        repeat (5) @(negedge clk);
        wr(8'h41);
        rd(1'b0, v); check("R6 busy kept", v, 8'h45);
        wait_done(k);
        rd(1'b1, v); check("R6 result", v, 8'h3C);
    endtask

    task automatic t_slow;
        logic [7:0] v;
        vin = 8'h96;
        wr(8'hC1);
        @(negedge clk); slow_tick = 1'b1;
        @(negedge clk); slow_tick = 1'b0;
        rd(1'b0, v); check("R8 tick ignored idle", v, 8'hC1);
        wr(8'hC5);
        repeat (20) @(negedge clk);
        check("R8 no step without tick", sar_code, 8'h80);
        for (int i = 0; i < 8; i++) begin
            repeat (2) @(negedge clk);
            check("R8 not done early", done_pulse, 0);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
        check("R8 done on 8th tick", done_pulse, 1);
        rd(1'b1, v); check("R8 result", v, 8'h96);
    endtask

    task automatic t_abort;
        logic [7:0] v;
        int seen;
        vin = 8'h11;
        wr(8'h81);
        wr(8'h85);
        repeat (40) @(negedge clk);
        wr(8'h00);
        check("R11 abort pulse", conv_abort, 1);
        rd(1'b0, v); check("R11 busy cleared", v, 8'h00);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done_pulse) seen++;
        end
        check("R11 no done", seen, 0);
        rd(1'b1, v); check("R11 result kept", v, 8'h96);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_start_while_disabled();
        t_convert(2'b00, 8'h00, 2, 4'h0);
        t_convert(2'b01, 8'hFF, 8, 4'h7);
        t_convert(2'b10, 8'hA5, 32, 4'h3);
        t_convert(2'b00, 8'h5A, 2, 4'hE);
        t_sw_clear_ignored();
        t_slow();
        t_abort();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule